// File: doc/BRIEF.md
# Seven-Operand Carry-Save Reducer

This block sums seven unsigned operands of equal width in one combinational layer. Every bit column has its own compression slice. The slice counts the seven primary bits of that column into a three-bit value. The low bit of that count joins the two carries arriving from the next lower column and from the column two places down, and a full adder merges the three into a sum bit and a carry bit. The middle and high bits of the count leave the slice as carries toward the columns one and two places up. These outgoing carries are formed from the primary bits alone, so no carry chain crosses columns before the final adder.

The array keeps the reduced pair: a sum vector and a carry vector. Each column's merge carry sits one place higher in the carry vector. A ripple adder then adds the two vectors into the total. The columns run three bits past the operand width, so the total of seven operands always fits and nothing is lost off the top. Operands arrive packed in one input bus and all outputs follow combinationally.

Top module: `cmp_seven_to_two`

## Requirements
- R1: `total_o` equals the arithmetic sum of the seven operands, where operand k occupies bits [k*OP_W +: OP_W] of `ops_i`, and the sum is given in RES_W = OP_W + 3 bits.
- R2: `sum_vec_o + carry_vec_o`, taken modulo 2^RES_W, equals the same arithmetic sum of the seven operands.
- R3: The final adder never produces a carry out of bit RES_W-1.
- R4: In each column, the three-bit count formed from the seven primary bits equals the number of ones among them.
- R5: Bit i of `sum_vec_o` equals the XOR of three terms: bit 0 of column i's count, bit 1 of column i-1's count, and bit 2 of column i-2's count. A term for a column below 0 is zero.
- R6: Bit i+1 of `carry_vec_o` equals the majority of the same three terms for column i, and bit 0 of `carry_vec_o` is always 0.
- R7: The slices at and above the top column send out no nonzero carry that would be dropped.
- R8: If one operand is nonzero and the others are zero, `sum_vec_o` equals that operand and `carry_vec_o` is zero.
- R9: If all seven operands are all ones, `total_o` equals 7*(2^OP_W - 1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ops_i | input | 7*OP_W | Seven packed operands; operand k at bits [k*OP_W +: OP_W] |
| sum_vec_o | output | OP_W+3 | Sum-weight vector of the reduced pair |
| carry_vec_o | output | OP_W+3 | Carry-weight vector of the reduced pair, already shifted into place |
| total_o | output | OP_W+3 | Final sum of the seven operands |

## Verification
The assertions are evaluated inside combinational processes. They assume every operand bit is a known 0 or 1, and each one is skipped while any input is unknown. The bench drives every bit of `ops_i` explicitly at all times, starting before the first sample. It runs all 16384 input patterns on a two-bit instance. It also drives all-ones, single-operand and random patterns on an eight-bit instance, and checks the column-level sum and carry bits against a per-column count model.

// File: rtl/cmp_pkg.sv
package cmp_pkg;
  localparam int unsigned NUM_ROWS = 7;
  localparam int unsigned CNT_W    = $clog2(NUM_ROWS + 1);

  typedef struct packed {
    logic w2;
    logic w1;
    logic w0;
  } count3_t;
endpackage

// File: rtl/cmp_full_adder.sv
module cmp_full_adder (
  input  logic a_i,
  input  logic b_i,
  input  logic c_i,
  output logic s_o,
  output logic co_o
);
  always_comb begin
    s_o  = a_i ^ b_i ^ c_i;
    co_o = (a_i & b_i) | (a_i & c_i) | (b_i & c_i);
  end
endmodule

// File: rtl/cmp_count7to3.sv
module cmp_count7to3
  import cmp_pkg::*;
(
  input  logic [NUM_ROWS-1:0] bits_i,
  output count3_t             cnt_o
);
  logic s_lo, k_lo, s_hi, k_hi, k_mid;

  // level one: two adders over six of the inputs
  cmp_full_adder u_fa_lo (.a_i(bits_i[0]), .b_i(bits_i[1]), .c_i(bits_i[2]),
                          .s_o(s_lo), .co_o(k_lo));
  cmp_full_adder u_fa_hi (.a_i(bits_i[3]), .b_i(bits_i[4]), .c_i(bits_i[5]),
                          .s_o(s_hi), .co_o(k_hi));
  // level two: unit weight
  cmp_full_adder u_fa_unit (.a_i(s_lo), .b_i(s_hi), .c_i(bits_i[6]),
                            .s_o(cnt_o.w0), .co_o(k_mid));
  // level three: weight two
  cmp_full_adder u_fa_two (.a_i(k_lo), .b_i(k_hi), .c_i(k_mid),
                           .s_o(cnt_o.w1), .co_o(cnt_o.w2));

  always_comb begin
    if (!$isunknown(bits_i)) begin
      p_count_r4: assert ($countones(bits_i) == int'(cnt_o))
        else $error("R4: count %0d for bits %b", cnt_o, bits_i);
    end
  end
endmodule

// File: rtl/cmp_slice7to2.sv
module cmp_slice7to2
  import cmp_pkg::*;
(
  input  logic [NUM_ROWS-1:0] prim_i,
  input  logic                cin_near_i,
  input  logic                cin_far_i,
  output logic                sum_o,
  output logic                carry_o,
  output logic                cout_near_o,
  output logic                cout_far_o
);
  count3_t cnt_w;

  cmp_count7to3 u_count (.bits_i(prim_i), .cnt_o(cnt_w));

  // incoming carries enter only this bottom adder
  cmp_full_adder u_merge (.a_i(cnt_w.w0), .b_i(cin_near_i), .c_i(cin_far_i),
                          .s_o(sum_o), .co_o(carry_o));

  always_comb begin
    cout_near_o = cnt_w.w1;
    cout_far_o  = cnt_w.w2;
  end

  always_comb begin
    if (!$isunknown({prim_i, cin_near_i, cin_far_i})) begin
      p_slice_weight_r5: assert (({1'b0, cnt_w.w0} + {1'b0, cin_near_i} + {1'b0, cin_far_i})
                                 == {carry_o, sum_o})
        else $error("R5: merge mismatch");
      p_slice_total_r6: assert (($countones(prim_i) + int'(cin_near_i) + int'(cin_far_i))
                                == (int'(sum_o) + 2 * int'(carry_o) + 2 * int'(cout_near_o)
                                    + 4 * int'(cout_far_o)))
        else $error("R6: slice weight sum mismatch");
    end
  end
endmodule

// File: rtl/cmp_ripple_add.sv
module cmp_ripple_add #(
  parameter int unsigned WIDTH = 11
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] s_o,
  output logic             cout_o
);
  logic [WIDTH:0] chain_w;

  assign chain_w[0] = 1'b0;

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    cmp_full_adder u_fa (.a_i(a_i[b]), .b_i(b_i[b]), .c_i(chain_w[b]),
                         .s_o(s_o[b]), .co_o(chain_w[b+1]));
  end

  assign cout_o = chain_w[WIDTH];
endmodule

// File: rtl/cmp_seven_to_two.sv
module cmp_seven_to_two
  import cmp_pkg::*;
#(
  parameter int unsigned OP_W = 8
) (
  input  logic [NUM_ROWS*OP_W-1:0]         ops_i,
  output logic [OP_W+$clog2(NUM_ROWS)-1:0] sum_vec_o,
  output logic [OP_W+$clog2(NUM_ROWS)-1:0] carry_vec_o,
  output logic [OP_W+$clog2(NUM_ROWS)-1:0] total_o
);
  localparam int unsigned RES_W = OP_W + $clog2(NUM_ROWS);

  logic [NUM_ROWS-1:0] col_bits [RES_W];
  logic [RES_W-1:0]    sum_w, merge_w, near_w, far_w;
  logic [RES_W-1:0]    cin_near_w, cin_far_w;
  logic                final_cout_w;

  for (genvar col = 0; col < RES_W; col++) begin : g_col
    for (genvar row = 0; row < NUM_ROWS; row++) begin : g_row
      if (col < OP_W) begin : g_live
        assign col_bits[col][row] = ops_i[row*OP_W + col];
      end else begin : g_pad
        assign col_bits[col][row] = 1'b0;
      end
    end

    if (col >= 1) begin : g_near
      assign cin_near_w[col] = near_w[col-1];
    end else begin : g_near0
      assign cin_near_w[col] = 1'b0;
    end

    if (col >= 2) begin : g_far
      assign cin_far_w[col] = far_w[col-2];
    end else begin : g_far0
      assign cin_far_w[col] = 1'b0;
    end

    cmp_slice7to2 u_slice (
      .prim_i      (col_bits[col]),
      .cin_near_i  (cin_near_w[col]),
      .cin_far_i   (cin_far_w[col]),
      .sum_o       (sum_w[col]),
      .carry_o     (merge_w[col]),
      .cout_near_o (near_w[col]),
      .cout_far_o  (far_w[col])
    );
  end

  assign sum_vec_o   = sum_w;
  assign carry_vec_o = {merge_w[RES_W-2:0], 1'b0};

  cmp_ripple_add #(.WIDTH(RES_W)) u_cpa (
    .a_i    (sum_w),
    .b_i    (carry_vec_o),
    .s_o    (total_o),
    .cout_o (final_cout_w)
  );

  logic [RES_W-1:0] ref_total;

  always_comb begin
    ref_total = '0;
    for (int k = 0; k < NUM_ROWS; k++) begin
      ref_total = ref_total + RES_W'(ops_i[k*OP_W +: OP_W]);
    end
  end

  always_comb begin
    if (!$isunknown(ops_i)) begin
      p_total_r1: assert (total_o == ref_total)
        else $error("R1: total %0d expected %0d", total_o, ref_total);
      p_pair_sum_r2: assert (RES_W'(sum_vec_o + carry_vec_o) == ref_total)
        else $error("R2: reduced pair does not add to operand sum");
      p_no_overflow_r3: assert (!final_cout_w)
        else $error("R3: final adder carried out");
      p_top_carry_zero_r7: assert (!merge_w[RES_W-1] && !near_w[RES_W-1]
                                   && !far_w[RES_W-1] && !far_w[RES_W-2])
        else $error("R7: carry lost off the top column");
    end
  end
endmodule

// File: tb/cmp_seven_to_two_tb.sv
module cmp_seven_to_two_tb;
  localparam int unsigned NW = 2;
  localparam int unsigned NR = NW + 3;
  localparam int unsigned WW = 8;
  localparam int unsigned WR = WW + 3;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic [7*NW-1:0] ops_n = '0;
  logic [NR-1:0]   sv_n, cv_n, tot_n;
  logic [7*WW-1:0] ops_w = '0;
  logic [WR-1:0]   sv_w, cv_w, tot_w;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  cmp_seven_to_two #(.OP_W(NW)) u_dut (
    .ops_i(ops_n), .sum_vec_o(sv_n), .carry_vec_o(cv_n), .total_o(tot_n));

  cmp_seven_to_two #(.OP_W(WW)) u_wide (
    .ops_i(ops_w), .sum_vec_o(sv_w), .carry_vec_o(cv_w), .total_o(tot_w));

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // column model from R4-R6, for widths up to 16 result bits
  task automatic check_cols(input int ow, input int rw, input logic [111:0] ops,
                            input logic [15:0] sv, input logic [15:0] cv);
    int cnt [16];
    logic [15:0] es, ec;
    for (int c = 0; c < rw; c++) begin
      cnt[c] = 0;
      if (c < ow)
        for (int k = 0; k < 7; k++) cnt[c] += int'(ops[k*ow + c]);
    end
    es = '0; ec = '0;
    for (int c = 0; c < rw; c++) begin
      logic t0, t1, t2;
      t0 = cnt[c][0];
      t1 = (c >= 1) ? cnt[c-1][1] : 1'b0;
      t2 = (c >= 2) ? cnt[c-2][2] : 1'b0;
      es[c] = t0 ^ t1 ^ t2;
      if (c + 1 < rw) ec[c+1] = (t0 & t1) | (t0 & t2) | (t1 & t2);
    end
    check("R5 sum vector", longint'(sv), longint'(es));
    check("R6 carry vector", longint'(cv), longint'(ec));
  endtask

  function automatic longint op_sum(input int ow, input logic [111:0] ops);
    longint s = 0;
    for (int k = 0; k < 7; k++) s += longint'((ops >> (k*ow)) & ((112'd1 << ow) - 1));
    return s;
  endfunction

  initial begin
    #(4 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    // all-zero inputs
    check("R1 zero total", longint'(tot_w), 0);
    check("R6 zero carry vector", longint'(cv_w), 0);

    // exhaustive on the narrow instance
    for (int v = 0; v < (1 << (7*NW)); v++) begin
      @(posedge clk);
      ops_n = (7*NW)'(v);
      @(negedge clk);
      check("R1 narrow total", longint'(tot_n), op_sum(NW, 112'(ops_n)));
      check("R2 narrow pair", longint'(NR'(sv_n + cv_n)), op_sum(NW, 112'(ops_n)));
      check("R6 carry bit0", longint'(cv_n[0]), 0);
      if ((v & 63) == 0) check_cols(NW, NR, 112'(ops_n), 16'(sv_n), 16'(cv_n));
    end

    // all-ones
    @(posedge clk);
    ops_w = '1;
    @(negedge clk);
    check("R9 all ones total", longint'(tot_w), 7 * 255);
    check_cols(WW, WR, 112'(ops_w), 16'(sv_w), 16'(cv_w));

    // single operand in each slot
    for (int k = 0; k < 7; k++) begin
      @(posedge clk);
      ops_w = '0;
      ops_w[k*WW +: WW] = 8'(8'hA5 + k * 17);
      @(negedge clk);
      check("R8 single sum vector", longint'(sv_w), longint'(8'(8'hA5 + k * 17)));
      check("R8 single carry vector", longint'(cv_w), 0);
    end

    // random patterns
    for (int n = 0; n < 400; n++) begin
      @(posedge clk);
      for (int k = 0; k < 7; k++) ops_w[k*WW +: WW] = 8'($urandom);
      @(negedge clk);
      check("R1 wide total", longint'(tot_w), op_sum(WW, 112'(ops_w)));
      check("R2 wide pair", longint'(WR'(sv_w + cv_w)), op_sum(WW, 112'(ops_w)));
      check_cols(WW, WR, 112'(ops_w), 16'(sv_w), 16'(cv_w));
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule